// File: doc/BRIEF.md
# Display Bias Rail Power-Up Sequencer

This block orders the start-up of the rails in a display bias supply and then watches them. Once the input supply is above its lockout level and the main enable is high, it walks through six timed ramps. The step-up converter starts first, then the negative pump together with the delayed-output gate driver, and last the positive pump. Only when all six ramps are done does it release the three-way slice switch from ground. The logic buck rail has its own enable and runs apart from this order. The reference runs whenever either enable is high.

Ramp lengths and the fault time-out are counted in ticks from a clock-derived strobe. Short-detect flags, the over-temperature flag and the gate-node-low flag are asynchronous. Each one passes through a two-flop synchroniser and then a two-sample agreement filter. A short flag counts only once its own rail is enabled. While a qualified fault is present, ramp progress stops and a time-out runs. If the fault clears first, the sequence carries on. If the time-out expires, every output is switched off and the block latches. An over-temperature flag latches at once. Only a low main enable or a lockout drop releases the latch.

Top module: `rail_bringup_ctrl`

## Requirements
- R1: While `lockout_ok` is low, every output is low and no ramp runs. Dropping `lockout_ok` in mid-sequence turns every rail enable off on the next clock.
- R2: Outside the latched state, `ref_en` equals `lockout_ok & (main_en | logic_en)`, and `buck_en` equals `lockout_ok & logic_en`, whatever the main sequence is doing.
- R3: With `tick` held high, each ramp lasts RAMP_TICKS+1 clocks, and ramp 1 begins on the clock that samples `main_en` high. `boost_en` rises at the start of ramp 3, which is 1+2*(RAMP_TICKS+1) clocks after `main_en` is driven high.
- R4: `npump_en` and `gate_drv_en` rise when ramp 4 ends, which is 1+4*(RAMP_TICKS+1) clocks after start. `ppump_en` rises at the start of ramp 6, after 1+5*(RAMP_TICKS+1) clocks. The sequence is complete after ramp 6, after 1+6*(RAMP_TICKS+1) clocks. A later rail is never on without the earlier ones.
- R5: `short_flags` bit 0 is the boost flag, bit 1 the logic flag, bit 2 the positive-pump flag and bit 3 the negative-pump flag. A flag counts only while its rail is enabled. Once it has been held for at least two filtered samples, it stops the ramp count for as long as it is present. A one-clock pulse has no effect.
- R6: A qualified fault that clears before FAULT_TICKS expire delays the sequence by its own duration and does not latch.
- R7: A qualified fault held for FAULT_TICKS+1 ticks latches the block. Every output is then low, `ref_en` and `buck_en` included.
- R8: A filtered `over_temp` while ramping or complete latches the block without waiting for the time-out.
- R9: The latched state persists after the fault goes away. It clears only when `main_en` is low or `lockout_ok` is low on a clock edge. After that, a high `main_en` starts a new sequence.
- R10: After completion, if `gate_low` is not asserted, the fault time-out runs and latches.
- R11: `gate_strong` is high only while `gate_drv_en` is high and the filtered `gate_low` is high.
- R12: `slice_sel` is 2'b00 (ground) until the sequence is complete. After that it is 2'b01 (lower reference) when `slice_ctl` is low and 2'b10 (positive pump) when `slice_ctl` is high. It is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timing strobe for ramp and time-out counts |
| lockout_ok | input | 1 | Input supply above lockout (synchronous) |
| main_en | input | 1 | Main sequence enable (synchronous) |
| logic_en | input | 1 | Logic buck enable (synchronous) |
| short_flags | input | 4 | Per-rail short detect, asynchronous |
| over_temp | input | 1 | Over-temperature flag, asynchronous |
| gate_low | input | 1 | Delayed-gate node below threshold, asynchronous |
| slice_ctl | input | 1 | Slice switch control (synchronous) |
| ref_en | output | 1 | Reference enable |
| buck_en | output | 1 | Logic buck enable |
| boost_en | output | 1 | Step-up converter soft-start/enable |
| npump_en | output | 1 | Negative pump enable |
| ppump_en | output | 1 | Positive pump enable |
| gate_drv_en | output | 1 | Delayed-gate pull-down driver enable |
| gate_strong | output | 1 | Delayed-gate driver in strong pull-down mode |
| slice_sel | output | 2 | Slice switch select: 00 ground, 01 lower ref, 10 positive pump |

## Verification
The hardest condition to reach from the ports is a fault that stalls the ramp count without latching. This needs a short flag whose rail is already on, held for fewer ticks than the time-out, while the sequence sits in the middle of a ramp. The stimulus watches for `boost_en` to rise and only then pulses the boost flag, for one clock or for ten. Because the filter delays the rising and falling edges equally, the stall is an exact number of clocks, and it shows up as a shift in when `npump_en` rises. A flag raised on a rail that is still off, kept up until that rail starts, checks the per-rail masking in the same way.

// File: rtl/rail_seq_pkg.sv
// Shared types for the rail bring-up sequencer.
// Assumes: nothing; pure declarations.
package rail_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RAMP  = 2'd1,
        SEQ_DONE  = 2'd2,
        SEQ_LATCH = 2'd3
    } seq_state_e;

    localparam logic [1:0] SLICE_GND  = 2'b00;
    localparam logic [1:0] SLICE_LOW  = 2'b01;
    localparam logic [1:0] SLICE_PUMP = 2'b10;

    // Filtered flag vector positions
    localparam int FLG_SHORT0 = 0;  // four short flags at 0..3
    localparam int FLG_HOT    = 4;
    localparam int FLG_GATE   = 5;
    localparam int FLG_COUNT  = 6;
endpackage

// File: rtl/flag_sync.sv
// Two-flop synchroniser followed by a two-sample agreement filter.
// Assumes: inputs may be asynchronous; a bit's output changes only after
// two consecutive synchronised samples agree.
module flag_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2, s3, q_r;
    logic [W-1:0] agree;

    assign agree = ~(s2 ^ s3);

    // Synchronise, delay one more sample, update where samples agree
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1  <= '0;
            s2  <= '0;
            s3  <= '0;
            q_r <= '0;
        end else begin
            s1  <= d;
            s2  <= s1;
            s3  <= s2;
            q_r <= (agree & s2) | (~agree & q_r);
        end
    end

    assign q = q_r;
endmodule

// File: rtl/tick_span.sv
// Tick counter that flags when LIMIT ticks have been counted since clear.
// Assumes: clear has priority over step; count saturates at LIMIT.
module tick_span #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count ticks, hold at the limit, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/rail_bringup_ctrl.sv
// Orders the start of display bias rails through timed ramps, then
// supervises them; latches off on persistent fault or over-temperature.
// Assumes: lockout_ok, main_en, logic_en, slice_ctl and tick are
// synchronous to clk; short, temperature and gate flags are not.
module rail_bringup_ctrl
    import rail_seq_pkg::*;
#(
    parameter int RAMP_TICKS  = 4000,
    parameter int FAULT_TICKS = 26000,
    parameter int N_RAMPS     = 6,
    parameter int BOOST_RAMP  = 3,
    parameter int NEG_RAMP    = 5,
    parameter int POS_RAMP    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       lockout_ok,
    input  logic       main_en,
    input  logic       logic_en,
    input  logic [3:0] short_flags,
    input  logic       over_temp,
    input  logic       gate_low,
    input  logic       slice_ctl,
    output logic       ref_en,
    output logic       buck_en,
    output logic       boost_en,
    output logic       npump_en,
    output logic       ppump_en,
    output logic       gate_drv_en,
    output logic       gate_strong,
    output logic [1:0] slice_sel
);
    localparam int IDX_W = $clog2(N_RAMPS + 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_RAMPS);
    localparam logic [IDX_W-1:0] IDX_BOOST = IDX_W'(BOOST_RAMP);
    localparam logic [IDX_W-1:0] IDX_NEG   = IDX_W'(NEG_RAMP);
    localparam logic [IDX_W-1:0] IDX_POS   = IDX_W'(POS_RAMP);

    seq_state_e           state, state_nx;
    logic [IDX_W-1:0]     idx, idx_nx;
    logic [FLG_COUNT-1:0] flt;
    logic                 running, complete, latched;
    logic                 ramp_done, fault_done, fault_any, short_live, gate_fault;

    flag_sync #(.W(FLG_COUNT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({gate_low, over_temp, short_flags}),
        .q     (flt)
    );

    assign running  = (state == SEQ_RAMP);
    assign complete = (state == SEQ_DONE);
    assign latched  = (state == SEQ_LATCH);

    // Rail enables derived from the current ramp index
    always_comb begin
        boost_en    = complete | (running && idx >= IDX_BOOST);
        npump_en    = complete | (running && idx >= IDX_NEG);
        ppump_en    = complete | (running && idx >= IDX_POS);
        gate_drv_en = npump_en;
    end

    assign ref_en      = lockout_ok & (main_en | logic_en) & ~latched;
    assign buck_en     = lockout_ok & logic_en & ~latched;
    assign gate_strong = gate_drv_en & flt[FLG_GATE];
    assign slice_sel   = !complete ? SLICE_GND : (slice_ctl ? SLICE_PUMP : SLICE_LOW);

    // Qualified faults: shorts only on enabled rails, gate check after completion
    assign short_live = |(flt[FLG_SHORT0 +: 4] & {npump_en, ppump_en, buck_en, boost_en});
    assign gate_fault = complete & ~flt[FLG_GATE];
    assign fault_any  = short_live | gate_fault;

    tick_span #(.LIMIT(RAMP_TICKS)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~running | ramp_done),
        .step  (tick & ~fault_any),
        .done  (ramp_done)
    );

    tick_span #(.LIMIT(FAULT_TICKS)) u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~fault_any | ~(running | complete)),
        .step  (tick),
        .done  (fault_done)
    );

    // Next-state and ramp index selection
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        if (!lockout_ok) begin
            state_nx = SEQ_IDLE;
            idx_nx   = '0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (main_en) begin
                    state_nx = SEQ_RAMP;
                    idx_nx   = IDX_W'(1);
                end
                SEQ_RAMP: begin
                    if (!main_en) begin
                        state_nx = SEQ_IDLE;
                        idx_nx   = '0;
                    end else if (flt[FLG_HOT] || fault_done) begin
                        state_nx = SEQ_LATCH;
                    end else if (ramp_done) begin
                        if (idx == IDX_LAST) state_nx = SEQ_DONE;
                        else                 idx_nx   = idx + 1'b1;
                    end
                end
                SEQ_DONE: begin
                    if (!main_en) begin
                        state_nx = SEQ_IDLE;
                        idx_nx   = '0;
                    end else if (flt[FLG_HOT] || fault_done) begin
                        state_nx = SEQ_LATCH;
                    end
                end
                SEQ_LATCH: if (!main_en) begin
                    state_nx = SEQ_IDLE;
                    idx_nx   = '0;
                end
                default: state_nx = SEQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end
endmodule

// File: rtl/rail_bringup_chk.sv
// Port-level properties of the rail sequencer, attached by bind.
// Assumes: the top module's port names.
module rail_bringup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       lockout_ok,
    input logic       main_en,
    input logic       logic_en,
    input logic [3:0] short_flags,
    input logic       over_temp,
    input logic       gate_low,
    input logic       slice_ctl,
    input logic       ref_en,
    input logic       buck_en,
    input logic       boost_en,
    input logic       npump_en,
    input logic       ppump_en,
    input logic       gate_drv_en,
    input logic       gate_strong,
    input logic [1:0] slice_sel
);
    p_lockout_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lockout_ok |=> !boost_en && !npump_en && !ppump_en);

    p_buck_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        buck_en |-> logic_en && lockout_ok);

    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ppump_en |-> npump_en) and (npump_en |-> boost_en) and (gate_drv_en |-> npump_en));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_en && main_en && lockout_ok) |=> (main_en && lockout_ok) |-> !ref_en);

    p_strong_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gate_strong |-> gate_drv_en);

    p_slice_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_sel != 2'b11) and (!ppump_en |-> slice_sel == 2'b00));
endmodule

bind rail_bringup_ctrl rail_bringup_chk u_chk (.*);

// File: tb/rail_bringup_ctrl_tb.sv
`timescale 1ns/1ps
module rail_bringup_ctrl_tb;
    localparam int RT = 8;
    localparam int FT = 20;

    logic clk = 0, rst_n = 0, tick = 1, lockout_ok = 0, main_en = 0, logic_en = 0;
    logic [3:0] short_flags = '0;
    logic over_temp = 0, gate_low = 0, slice_ctl = 0, gate_auto = 1;
    logic ref_en, buck_en, boost_en, npump_en, ppump_en, gate_drv_en, gate_strong;
    logic [1:0] slice_sel;
    int cyc = 0, checks = 0, failures = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    // Simple model of the gate node: falls one cycle after the driver starts
    always @(negedge clk) gate_low <= gate_auto & gate_drv_en;

    rail_bringup_ctrl #(.RAMP_TICKS(RT), .FAULT_TICKS(FT)) u_dut (.*);

    function automatic int exp_at(int ramps);
        return 1 + ramps * (RT + 1);
    endfunction

    function automatic logic [1:0] exp_slice(logic ctl);
        return ctl ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise main_en and time each rail; optional boost-flag pulse once boost starts
    task automatic bringup(input int pulse_len, output int tb, output int tn,
                           output int tp, output int td);
        int c0, left;
        bit pulsed;
        tb = -1; tn = -1; tp = -1; td = -1; left = 0; pulsed = 0;
        @(negedge clk);
        main_en = 1;
        c0 = cyc;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (left > 0) begin
                left--;
                if (left == 0) short_flags[0] = 0;
            end
            if (tb < 0 && boost_en) begin
                tb = cyc - c0;
                if (pulse_len > 0 && !pulsed) begin
                    short_flags[0] = 1;
                    left = pulse_len;
                    pulsed = 1;
                end
            end
            if (tn < 0 && npump_en) tn = cyc - c0;
            if (tp < 0 && ppump_en) tp = cyc - c0;
            if (td < 0 && slice_sel != 2'b00) begin
                td = cyc - c0;
                break;
            end
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        main_en = 0;
        wait_n(2);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int tb, tn, tp, td;
        void'($urandom(32'd4242));
        wait_n(3);
        chk(!ref_en && !buck_en && !boost_en && slice_sel == 0, "R1 reset state", boost_en, 0);
        rst_n = 1;
        wait_n(2);

        // R1: lockout holds everything off
        main_en = 1; logic_en = 1;
        wait_n(20);
        chk(!boost_en && !ref_en && !buck_en, "R1 lockout low", {ref_en, boost_en}, 0);
        main_en = 0; lockout_ok = 1;
        wait_n(2);

        // R2: random logic enable with main off
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            logic_en = 1'($urandom);
            #1;
            chk(ref_en == logic_en && buck_en == logic_en, "R2 ref/buck follow logic_en",
                {ref_en, buck_en}, {logic_en, logic_en});
        end
        logic_en = 1;

        // R3/R4: nominal bring-up timing
        bringup(0, tb, tn, tp, td);
        chk(tb == exp_at(2), "R3 boost start", tb, exp_at(2));
        chk(tn == exp_at(4), "R4 npump start", tn, exp_at(4));
        chk(tp == exp_at(5), "R4 ppump start", tp, exp_at(5));
        chk(td == exp_at(6), "R12 slice release", td, exp_at(6));
        chk(gate_drv_en && ref_en && buck_en, "R4 gate driver on", gate_drv_en, 1);
        wait_n(6);
        chk(gate_strong, "R11 strong pull-down after node low", gate_strong, 1);
        chk(ref_en, "R10 no latch when gate node low", ref_en, 1);

        // R12: random slice control once complete
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            slice_ctl = 1'($urandom);
            #1;
            chk(slice_sel == exp_slice(slice_ctl), "R12 slice select", slice_sel, exp_slice(slice_ctl));
        end
        go_idle();
        chk(!gate_strong && !gate_drv_en, "R11 strong off with driver off", gate_strong, 0);

        // R5: a one-clock pulse is filtered out
        bringup(1, tb, tn, tp, td);
        chk(tn == exp_at(4), "R5 single-cycle glitch ignored", tn, exp_at(4));
        go_idle();

        // R6: short fault stalls then resumes
        bringup(10, tb, tn, tp, td);
        chk(tn == exp_at(4) + 10, "R6 stall by fault length", tn, exp_at(4) + 10);
        chk(td == exp_at(6) + 10, "R6 completes after stall", td, exp_at(6) + 10);
        chk(ref_en, "R6 no latch", ref_en, 1);

        // R7/R9: persistent fault latches; clears only via main_en low
        short_flags[0] = 1;
        wait_n(FT + 10);
        chk(!ref_en && !buck_en && !boost_en && !ppump_en, "R7 latched off",
            {ref_en, buck_en, boost_en}, 0);
        short_flags[0] = 0;
        wait_n(20);
        chk(!ref_en && !boost_en, "R9 latch persists", ref_en, 0);
        main_en = 0;
        wait_n(1);
        chk(ref_en == logic_en && buck_en, "R9 latch cleared by main_en low", ref_en, 1);

        // R5/R7: positive-pump flag masked until that rail starts
        short_flags[2] = 1;
        bringup(0, tb, tn, tp, td);
        chk(tn == exp_at(4), "R5 masked flag no stall", tn, exp_at(4));
        chk(td == -1, "R5 stall after ppump on", td, -1);
        chk(!ref_en && !ppump_en, "R7 latched after masked flag qualifies", ref_en, 0);
        short_flags[2] = 0;
        go_idle();

        // R8/R9: over-temperature latch, cleared by lockout drop
        bringup(0, tb, tn, tp, td);
        @(negedge clk); over_temp = 1;
        wait_n(8);
        chk(!boost_en && !ref_en, "R8 over-temp latch", boost_en, 0);
        over_temp = 0;
        wait_n(10);
        chk(!boost_en && !ref_en, "R9 over-temp latch persists", ref_en, 0);
        lockout_ok = 0;
        wait_n(1);
        lockout_ok = 1;
        wait_n(1);
        chk(ref_en, "R9 lockout clears latch", ref_en, 1);
        wait_n(exp_at(2) + 2);
        chk(boost_en, "R9 restart after clear", boost_en, 1);

        // R1: lockout drop mid-sequence
        @(negedge clk); lockout_ok = 0;
        @(negedge clk);
        chk(!boost_en && !ref_en && slice_sel == 0, "R1 lockout mid-run", boost_en, 0);
        lockout_ok = 1;
        go_idle();

        // R10: gate node never falls
        gate_auto = 0;
        bringup(0, tb, tn, tp, td);
        chk(td == exp_at(6) && !gate_strong, "R10 completes weak", td, exp_at(6));
        wait_n(FT + 8);
        chk(!ref_en && !boost_en, "R10 gate fault latch", ref_en, 0);
        gate_auto = 1;
        go_idle();

        finish_run();
    end
endmodule